// File: doc/BRIEF.md
# Push-Button Byte Editor with Hex Readout

This block gives sixteen one-byte storage cells and four push-buttons to edit them by hand. One button pair steps a 4-bit location pointer up or down. The other pair adds or subtracts one from the byte at that location. Every edit goes straight back into storage, so a value is still there when the pointer returns to its location. Three seven-segment digits are driven at all times. One shows the pointer as a hex digit. The other two show the byte being edited as two hex digits.

The key lines are asynchronous button levels. Each key passes through a two-stage synchronizer and a rising-edge detector, so one press gives one step however long it is held. A small controller has two states. `ST_CLEAR` runs first: after reset it writes 00 into all sixteen cells, one per cycle, and during that time every key is ignored. The transition `ST_CLEAR -> ST_READY` happens once the last cell has been written. `ST_READY` then carries out edit and move commands. It stays there until reset, and reset always re-enters `ST_CLEAR`. A pointer move reloads the working byte in the same cycle, from a combinational read at the new pointer.

Top module: `hexedit_top`

## Requirements
- R1: While `rst` is high, all three digits show glyph 0. Each of the sixteen cells holds 00 once the clearing sweep that follows reset has finished.
- R2: A rising edge on `key[3]`, with no other key held, adds one to the pointer, wrapping from F to 0.
- R3: A rising edge on `key[2]`, with no other key held, subtracts one from the pointer, wrapping from 0 to F.
- R4: A rising edge on `key[1]`, with no other key held, adds one to the working byte modulo 256 and stores the result at the current location.
- R5: A rising edge on `key[0]`, with no other key held, subtracts one from the working byte modulo 256 and stores the result at the current location.
- R6: While more than one key is held, the pointer and the byte do not change. This also covers a key that rises while another key is already held.
- R7: A single press gives exactly one step, whatever its hold time.
- R8: After any pointer move, the byte digits show the value stored at the new location, including any edit made there earlier.
- R9: Segment vectors are active-high, ordered {g,f,e,d,c,b,a}. The glyphs for 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R10: Key presses during the clearing sweep, which lasts 16 cycles after reset is released, have no effect.
- R11: `seg_hi` shows bits 7:4 of the working byte and `seg_lo` shows bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key | input | 4 | Button levels, active high: 3 up, 2 down, 1 increment, 0 decrement |
| seg_addr | output | 7 | Pointer digit segments {g..a} |
| seg_hi | output | 7 | High nibble digit segments {g..a} |
| seg_lo | output | 7 | Low nibble digit segments {g..a} |

## Verification
Two functions can fall in the same cycle: the clearing sweep after reset and a navigation press. The bench releases reset and presses the up key on the very next cycle, so its edge arrives well inside the 16-cycle sweep. It then waits for the sweep to end. It judges the result from the pointer digit, which must still read 0, and from a later move to location 1, whose edited byte must now read 00. A second overlap, a key rising while another key is held, is judged the same way through the digits.

// File: rtl/hexedit_pkg.sv
package hexedit_pkg;

    localparam int KEYS = 4;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_INC,
        OP_DEC,
        OP_UP,
        OP_DOWN
    } op_e;

    typedef enum logic {
        ST_CLEAR,
        ST_READY
    } st_e;

    // Active-high {g,f,e,d,c,b,a}
    function automatic logic [6:0] hex_glyph(input logic [3:0] n);
        logic [6:0] s;
        case (n)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h39;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            default: s = 7'h71;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/key_front.sv
module key_front #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] key,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_key
        logic s1, s2, prev;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1   <= 1'b0;
                s2   <= 1'b0;
                prev <= 1'b0;
            end else begin
                s1   <= key[i];
                s2   <= s1;
                prev <= s2;
            end
        end
        assign lvl[i]  = s2;
        assign rise[i] = s2 & ~prev;
    end
endmodule

// File: rtl/key_decode.sv
module key_decode
    import hexedit_pkg::*;
(
    input  logic [KEYS-1:0] lvl,
    input  logic [KEYS-1:0] rise,
    output op_e             op
);
    logic solo;

    // Accept only when the rising key is the only key held
    assign solo = (rise != '0) && (rise == lvl) && $onehot(lvl);

    always_comb begin
        op = OP_NONE;
        if (solo) begin
            unique case (lvl)
                4'b1000: op = OP_UP;
                4'b0100: op = OP_DOWN;
                4'b0010: op = OP_INC;
                4'b0001: op = OP_DEC;
                default: op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/byte_store.sv
module byte_store #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/edit_fsm.sv
module edit_fsm
    import hexedit_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           op,
    input  logic [DW-1:0] rdata,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic [AW-1:0] raddr,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] work,
    output logic          ready
);
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    st_e           state, state_n;
    logic [AW-1:0] clr_idx, clr_idx_n;
    logic [AW-1:0] addr_n;
    logic [DW-1:0] work_n;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_CLEAR;
            clr_idx <= '0;
            addr    <= '0;
            work    <= '0;
        end else begin
            state   <= state_n;
            clr_idx <= clr_idx_n;
            addr    <= addr_n;
            work    <= work_n;
        end
    end

    // Next state and outputs
    always_comb begin
        state_n   = state;
        clr_idx_n = clr_idx;
        addr_n    = addr;
        work_n    = work;
        we        = 1'b0;
        waddr     = addr;
        wdata     = work;
        raddr     = addr;
        unique case (state)
            ST_CLEAR: begin
                we        = 1'b1;
                waddr     = clr_idx;
                wdata     = '0;
                clr_idx_n = clr_idx + 1'b1;
                if (clr_idx == LAST) state_n = ST_READY;
            end
            ST_READY: begin
                unique case (op)
                    OP_INC: begin
                        work_n = work + 1'b1;
                        we     = 1'b1;
                        wdata  = work_n;
                    end
                    OP_DEC: begin
                        work_n = work - 1'b1;
                        we     = 1'b1;
                        wdata  = work_n;
                    end
                    OP_UP: begin
                        addr_n = addr + 1'b1;
                        raddr  = addr_n;
                        work_n = rdata;
                    end
                    OP_DOWN: begin
                        addr_n = addr - 1'b1;
                        raddr  = addr_n;
                        work_n = rdata;
                    end
                    default: ;
                endcase
            end
        endcase
    end

    assign ready = (state == ST_READY);
endmodule

// File: rtl/hexedit_top.sv
module hexedit_top
    import hexedit_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] key,
    output logic [6:0] seg_addr,
    output logic [6:0] seg_hi,
    output logic [6:0] seg_lo
);
    localparam int BYTE_DIGITS = DW / 4;

    logic [KEYS-1:0] key_lvl, key_rise;
    op_e             op;
    logic            we, ready;
    logic [AW-1:0]   waddr, raddr, addr_q;
    logic [DW-1:0]   wdata, rdata, work_q;
    logic [6:0]      byte_seg [BYTE_DIGITS];

    key_front #(.N(KEYS)) u_front (
        .clk (clk),
        .rst (rst),
        .key (key),
        .lvl (key_lvl),
        .rise(key_rise)
    );

    key_decode u_dec (
        .lvl (key_lvl),
        .rise(key_rise),
        .op  (op)
    );

    edit_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .rdata(rdata),
        .we   (we),
        .waddr(waddr),
        .wdata(wdata),
        .raddr(raddr),
        .addr (addr_q),
        .work (work_q),
        .ready(ready)
    );

    byte_store #(.AW(AW), .DW(DW)) u_store (
        .clk  (clk),
        .we   (we),
        .waddr(waddr),
        .wdata(wdata),
        .raddr(raddr),
        .rdata(rdata)
    );

    for (genvar d = 0; d < BYTE_DIGITS; d++) begin : g_digit
        assign byte_seg[d] = hex_glyph(work_q[4*d +: 4]);
    end

    assign seg_addr = hex_glyph(addr_q);
    assign seg_lo   = byte_seg[0];
    assign seg_hi   = byte_seg[1];
endmodule

// File: rtl/hexedit_chk.sv
module hexedit_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] key_lvl,
    input logic [3:0] addr,
    input logic [7:0] work,
    input logic       ready
);
    // R2 / R3: pointer only ever moves by one step
    p_addr_unit_step_r2: assert property (@(posedge clk) disable iff (rst)
        (addr != $past(addr)) |->
            ((addr == $past(addr) + 4'd1) || (addr == $past(addr) - 4'd1)));

    // R4 / R5: byte changes in place only by one step
    p_byte_unit_step_r4: assert property (@(posedge clk) disable iff (rst)
        ((addr == $past(addr)) && (work != $past(work))) |->
            ((work == $past(work) + 8'd1) || (work == $past(work) - 8'd1)));

    // R6: several keys held leaves pointer and byte alone
    p_multi_key_idle_r6: assert property (@(posedge clk) disable iff (rst)
        ($countones(key_lvl) > 1) |=> ($stable(addr) && $stable(work)));

    // R10: pointer frozen during the clearing sweep
    p_clear_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        (!ready) |=> $stable(addr));

    // R1: sweep ends at location 0 showing 00
    p_clear_done_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ((addr == 4'd0) && (work == 8'd0)));
endmodule

bind hexedit_top hexedit_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .key_lvl(key_lvl),
    .addr   (addr_q),
    .work   (work_q),
    .ready  (ready)
);

// File: tb/hexedit_top_tb.sv
`timescale 1ns/1ps
module hexedit_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] key = 4'b0000;
    logic [6:0] seg_addr, seg_hi, seg_lo;
    int         n_vec = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;

    hexedit_top u_dut (
        .clk     (clk),
        .rst     (rst),
        .key     (key),
        .seg_addr(seg_addr),
        .seg_hi  (seg_hi),
        .seg_lo  (seg_lo)
    );

    // {key, expected pointer, expected byte}
    localparam logic [15:0] VEC [16] = '{
        16'h2001, 16'h2002, 16'h8100, 16'h11FF,
        16'h4002, 16'h4F00, 16'h1FFF, 16'h2F00,
        16'h1FFF, 16'h8002, 16'h81FF, 16'hA1FF,
        16'h31FF, 16'hF1FF, 16'h01FF, 16'h8200
    };

    // R9 glyph table
    function automatic logic [6:0] glyph(input logic [3:0] n);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D,
                               7'h7D, 7'h07, 7'h7F, 7'h6F, 7'h77, 7'h7C,
                               7'h39, 7'h5E, 7'h79, 7'h71};
        return t[n];
    endfunction

    function automatic string req_of(input logic [3:0] k);
        case (k)
            4'b1000: return "R2 R8";
            4'b0100: return "R3 R8";
            4'b0010: return "R4";
            4'b0001: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [6:0] got, input logic [6:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [3:0] a,
                             input logic [7:0] b);
        check(req, "seg_addr", seg_addr, glyph(a));
        check(req, "seg_hi", seg_hi, glyph(b[7:4]));
        check(req, "seg_lo", seg_lo, glyph(b[3:0]));
    endtask

    task automatic press(input logic [3:0] k, input int hold);
        @(negedge clk) key = k;
        repeat (hold) @(negedge clk);
        key = 4'b0000;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] a;
        // R1: reset state
        repeat (3) @(negedge clk);
        check_all("R1", 4'h0, 8'h00);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check_all("R1", 4'h0, 8'h00);

        // Table walk; hold time varies for R7
        for (int i = 0; i < 16; i++) begin
            press(VEC[i][15:12], 1 + (i % 4) * 5);
            check_all(req_of(VEC[i][15:12]), VEC[i][11:8], VEC[i][7:0]);
        end

        // R11: distinct nibbles, pointer 2 byte 00 -> FF -> FE
        press(4'b0001, 2);
        press(4'b0001, 2);
        check("R11", "seg_hi", seg_hi, 7'h71);
        check("R11", "seg_lo", seg_lo, 7'h79);

        // R7: very long hold gives a single step
        press(4'b1000, 40);
        check_all("R7", 4'h3, 8'h00);

        // R6: key1 rises while key3 is still held
        @(negedge clk) key = 4'b1000;
        repeat (6) @(negedge clk);
        key = 4'b1010;
        repeat (6) @(negedge clk);
        key = 4'b0000;
        repeat (5) @(negedge clk);
        check_all("R6", 4'h4, 8'h00);

        // R9: walk the pointer through every glyph
        a = 4'h4;
        for (int j = 0; j < 16; j++) begin
            press(4'b1000, 1);
            a = a + 4'h1;
            check("R9", "seg_addr", seg_addr, glyph(a));
        end

        // R10 and R1: reset, press during the sweep, then inspect location 1
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1", 4'h0, 8'h00);
        rst = 1'b0;
        key = 4'b1000;
        repeat (3) @(negedge clk);
        key = 4'b0000;
        repeat (25) @(negedge clk);
        check_all("R10", 4'h0, 8'h00);
        press(4'b1000, 2);
        check_all("R1", 4'h1, 8'h00);
        press(4'b0100, 2);
        press(4'b0100, 2);
        check_all("R1", 4'hF, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule